// File: doc/BRIEF.md
# Packet Transfer FIFO Engine

This block is a register-programmed mover that carries a packet of bytes between a 32-bit CPU register port and an external chip-select bus, staging the data in an internal FIFO. Software programs a bus start address, a 24-bit packet length, a chip select and a direction. A byte-wide start strobe then launches the transfer. The packet may be much longer than the FIFO, so the CPU keeps the FIFO fed (outbound) or drained (inbound) while the engine streams words across the external interface.

The external side is a valid/ready word handshake that carries address, chip select and direction. A status register reports the bytes moved so far, a completion flag and an abort flag. A single interrupt line combines completion and abort under separate masks and a master enable. A watermark alarm pin tells a DMA requester when the FIFO wants service in the active direction. Two reset bits in the enable register flush the datapath and cut off a transfer that is in progress.

Registers (CPU byte offsets): 0x00 length [23:0] with the start strobe at bit 24 (byte lane 3); 0x04 bus start address; 0x08 control (chip select [31:24], inbound select bit 16, spare mode bit 3); 0x0C enable (reset bits 24 and 16, error mask 9, completion mask 8, master 0); 0x14 status (abort 28, complete 24, bytes done [23:0]); 0x40 FIFO data window; 0x44 FIFO status (alarm 18, full 17, empty 16, fill in bytes [15:0]); 0x48 granularity code [2:0]; 0x4C watermark in bytes.

Top module: `pkt_xfer_fifo`

## Requirements
- R1: After synchronous reset every register reads zero, the FIFO status reads 0x00010000 (empty only), and irq, alarm and ext_valid are low.
- R2: A transfer starts only on a CPU write to offset 0x00 with byte enable 3 set and data bit 24 set. A length write with byte enable 3 clear moves nothing.
- R3: Outbound (bit 16 of control clear), FIFO words leave on the external port in push order, the first at the programmed start address, each next one 4 higher.
- R4: Inbound (bit 16 of control set), words taken on the external port enter the FIFO and are read back from offset 0x40 in arrival order.
- R5: Bytes done grows by 4 per word moved, never passes the programmed length (the last word reports exactly the length), and at that point the completion flag (status bit 24) sets and no more words move.
- R6: A packet longer than the FIFO runs to completion while the CPU keeps feeding or draining the FIFO.
- R7: A CPU write to the data window while the FIFO is full is dropped; the fill never exceeds the FIFO size.
- R8: Writing a 1 to status bit 24 clears the completion flag and leaves the byte count in place; writing a 1 to bit 28 clears the abort flag.
- R9: While either reset bit is set the FIFO is emptied, the byte count and completion flag clear and the transfer stops; the abort flag (bit 28) sets if a transfer was active.
- R10: irq is high one cycle after master enable AND ((complete AND enable bit 8) OR (abort AND enable bit 9)) holds, and low otherwise.
- R11: The alarm pin (and FIFO status bit 18) is high when the master enable is on and, outbound, the fill in bytes is below the watermark, or, inbound, fill plus watermark reaches the FIFO size.
- R12: With the master enable off no external word is offered; the transfer resumes once it is set.
- R13: ext_cs carries control bits [31:24] and ext_write is high for outbound and low for inbound transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_re | input | 1 | CPU register read strobe |
| cpu_addr | input | 7 | CPU byte offset |
| cpu_be | input | 4 | Byte enables, bit 3 is the most significant byte |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data, valid the cycle after cpu_re |
| irq | output | 1 | Combined completion/abort interrupt |
| alarm | output | 1 | FIFO watermark request |
| ext_valid | output | 1 | External word offered |
| ext_ready | input | 1 | External side accepts/supplies the word |
| ext_write | output | 1 | High outbound, low inbound |
| ext_cs | output | 8 | Chip select |
| ext_addr | output | 32 | External byte address of the current word |
| ext_wdata | output | 32 | Outbound data word |
| ext_rdata | input | 32 | Inbound data word |

## Verification
The bench builds the block with a 64-byte FIFO (16 words) instead of the default 512 bytes. That small depth lets a 256-byte outbound packet and a 128-byte inbound packet run several times past the FIFO size in a short run, makes the full-FIFO drop and the inbound watermark reachable with a handful of words, and keeps external backpressure visible while the FIFO wraps.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  localparam int LEN_W = 24;

  localparam logic [6:0] OFS_LEN   = 7'h00;
  localparam logic [6:0] OFS_BASE  = 7'h04;
  localparam logic [6:0] OFS_CTRL  = 7'h08;
  localparam logic [6:0] OFS_ENA   = 7'h0C;
  localparam logic [6:0] OFS_STAT  = 7'h14;
  localparam logic [6:0] OFS_DATA  = 7'h40;
  localparam logic [6:0] OFS_FSTAT = 7'h44;
  localparam logic [6:0] OFS_GRAN  = 7'h48;
  localparam logic [6:0] OFS_WMARK = 7'h4C;

  localparam int BIT_GO     = 24;
  localparam int BIT_RSTA   = 24;
  localparam int BIT_RSTB   = 16;
  localparam int BIT_ERREN  = 9;
  localparam int BIT_DONEEN = 8;
  localparam int BIT_MASTER = 0;
  localparam int BIT_INB    = 16;
  localparam int BIT_DONE   = 24;
  localparam int BIT_ABORT  = 28;
endpackage

// File: rtl/pxf_fifo.sv
module pxf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/pxf_engine.sv
module pxf_engine #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             start,
  input  logic             master,
  input  logic             rd_mode,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  input  logic             ext_ready,
  input  logic             clr_done,
  input  logic             clr_abort,
  input  logic [LEN_W-1:0] len,
  input  logic [31:0]      base,
  output logic             ext_valid,
  output logic             fire,
  output logic             busy,
  output logic             done_flg,
  output logic             abort_flg,
  output logic [LEN_W-1:0] cnt,
  output logic [31:0]      ext_addr
);
  logic [LEN_W:0] remain;
  logic           last_word;

  assign remain    = {1'b0, len} - {1'b0, cnt};
  assign last_word = (remain <= (LEN_W+1)'(4));
  assign ext_valid = busy & master & ~flush & (rd_mode ? ~fifo_full : ~fifo_empty);
  assign fire      = ext_valid & ext_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done_flg  <= 1'b0;
      abort_flg <= 1'b0;
      cnt       <= '0;
      ext_addr  <= '0;
    end else if (flush) begin
      busy      <= 1'b0;
      done_flg  <= 1'b0;
      cnt       <= '0;
      abort_flg <= abort_flg | busy;
    end else begin
      if (clr_done)  done_flg  <= 1'b0;
      if (clr_abort) abort_flg <= 1'b0;
      if (start && !busy) begin
        busy      <= (len != '0);
        done_flg  <= (len == '0);
        abort_flg <= 1'b0;
        cnt       <= '0;
        ext_addr  <= base;
      end else if (fire) begin
        ext_addr <= ext_addr + 32'd4;
        if (last_word) begin
          cnt      <= len;
          busy     <= 1'b0;
          done_flg <= 1'b1;
        end else begin
          cnt <= cnt + LEN_W'(4);
        end
      end
    end
  end
endmodule

// File: rtl/pkt_xfer_fifo.sv
module pkt_xfer_fifo #(
  parameter int FIFO_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_we,
  input  logic        cpu_re,
  input  logic [6:0]  cpu_addr,
  input  logic [3:0]  cpu_be,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        irq,
  output logic        alarm,
  output logic        ext_valid,
  input  logic        ext_ready,
  output logic        ext_write,
  output logic [7:0]  ext_cs,
  output logic [31:0] ext_addr,
  output logic [31:0] ext_wdata,
  input  logic [31:0] ext_rdata
);
  import pxf_pkg::*;

  localparam int DEPTH = FIFO_BYTES / 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int LB_W  = AW + 3;
  localparam int WM_W  = $clog2(FIFO_BYTES);

  logic [LEN_W-1:0] len_q;
  logic [31:0]      base_q;
  logic [7:0]       cs_q;
  logic             rd_q, m3_q;
  logic             rsta_q, rstb_q, erren_q, doneen_q, master_q;
  logic [2:0]       gran_q;
  logic [WM_W-1:0]  wm_q;
  logic             alarm_q;

  logic             flush, start, clr_done, clr_abort;
  logic             fire, busy, done_flg, abort_flg;
  logic [LEN_W-1:0] cnt;
  logic             f_push, f_pop, f_empty, f_full;
  logic [31:0]      f_din, f_dout;
  logic [AW:0]      fifo_lvl;
  logic [LB_W-1:0]  lvl_b;
  logic             alarm_d;

  assign flush     = rsta_q | rstb_q;
  assign start     = cpu_we && cpu_addr == OFS_LEN && cpu_be[3] && cpu_wdata[BIT_GO];
  assign clr_done  = cpu_we && cpu_addr == OFS_STAT && cpu_wdata[BIT_DONE];
  assign clr_abort = cpu_we && cpu_addr == OFS_STAT && cpu_wdata[BIT_ABORT];

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0; base_q <= '0; cs_q <= '0; rd_q <= 1'b0; m3_q <= 1'b0;
      rsta_q <= 1'b0; rstb_q <= 1'b0; erren_q <= 1'b0; doneen_q <= 1'b0;
      master_q <= 1'b0; gran_q <= '0; wm_q <= '0;
    end else if (cpu_we) begin
      case (cpu_addr)
        OFS_LEN: begin
          for (int i = 0; i < 3; i++)
            if (cpu_be[i]) len_q[8*i +: 8] <= cpu_wdata[8*i +: 8];
        end
        OFS_BASE: base_q <= cpu_wdata;
        OFS_CTRL: begin
          cs_q <= cpu_wdata[31:24];
          rd_q <= cpu_wdata[BIT_INB];
          m3_q <= cpu_wdata[3];
        end
        OFS_ENA: begin
          rsta_q   <= cpu_wdata[BIT_RSTA];
          rstb_q   <= cpu_wdata[BIT_RSTB];
          erren_q  <= cpu_wdata[BIT_ERREN];
          doneen_q <= cpu_wdata[BIT_DONEEN];
          master_q <= cpu_wdata[BIT_MASTER];
        end
        OFS_GRAN:  gran_q <= cpu_wdata[2:0];
        OFS_WMARK: wm_q   <= cpu_wdata[WM_W-1:0];
        default: ;
      endcase
    end
  end

  // FIFO source/sink steering by direction
  assign f_push = rd_q ? fire : (cpu_we && cpu_addr == OFS_DATA);
  assign f_pop  = rd_q ? (cpu_re && cpu_addr == OFS_DATA) : fire;
  assign f_din  = rd_q ? ext_rdata : cpu_wdata;

  pxf_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush),
    .push(f_push), .din(f_din), .pop(f_pop), .dout(f_dout),
    .level(fifo_lvl), .empty(f_empty), .full(f_full)
  );

  pxf_engine #(.LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst(rst), .flush(flush), .start(start), .master(master_q),
    .rd_mode(rd_q), .fifo_empty(f_empty), .fifo_full(f_full),
    .ext_ready(ext_ready), .clr_done(clr_done), .clr_abort(clr_abort),
    .len(len_q), .base(base_q), .ext_valid(ext_valid), .fire(fire),
    .busy(busy), .done_flg(done_flg), .abort_flg(abort_flg), .cnt(cnt),
    .ext_addr(ext_addr)
  );

  assign ext_write = ~rd_q;
  assign ext_cs    = cs_q;
  assign ext_wdata = f_dout;
  assign lvl_b     = {fifo_lvl, 2'b00};

  assign alarm_d = master_q & ~flush &
                   (rd_q ? (32'(lvl_b) + 32'(wm_q) >= 32'(FIFO_BYTES))
                         : (32'(lvl_b) < 32'(wm_q)));

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
      irq     <= master_q & ((done_flg & doneen_q) | (abort_flg & erren_q));
    end
  end
  assign alarm = alarm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else if (cpu_re) begin
      case (cpu_addr)
        OFS_LEN:   cpu_rdata <= 32'(len_q);
        OFS_BASE:  cpu_rdata <= base_q;
        OFS_CTRL:  cpu_rdata <= {cs_q, 7'd0, rd_q, 12'd0, m3_q, 3'd0};
        OFS_ENA:   cpu_rdata <= {7'd0, rsta_q, 7'd0, rstb_q, 6'd0,
                                 erren_q, doneen_q, 7'd0, master_q};
        OFS_STAT:  cpu_rdata <= {3'd0, abort_flg, 3'd0, done_flg, cnt};
        OFS_DATA:  cpu_rdata <= f_dout;
        OFS_FSTAT: cpu_rdata <= {13'd0, alarm_q, f_full, f_empty, 16'(lvl_b)};
        OFS_GRAN:  cpu_rdata <= 32'(gran_q);
        OFS_WMARK: cpu_rdata <= 32'(wm_q);
        default:   cpu_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pxf_checker.sv
module pxf_checker #(
  parameter int FIFO_BYTES = 512
) (
  input logic        clk,
  input logic        rst,
  input logic        flush,
  input logic        master,
  input logic        ext_valid,
  input logic        ext_ready,
  input logic [31:0] ext_addr,
  input logic        irq,
  input logic        busy,
  input logic        done_flg,
  input logic [23:0] cnt,
  input logic [23:0] len,
  input logic [$clog2(FIFO_BYTES/4):0] level
);
  localparam int DEPTH = FIFO_BYTES / 4;

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (ext_valid && ext_ready) |=> (ext_addr == $past(ext_addr) + 32'd4));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt < len));

  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_flg |-> !ext_valid);

  a_r7_level_bound: assert property (@(posedge clk) disable iff (rst)
    32'(level) <= DEPTH);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0 && cnt == '0 && !done_flg && !busy));

  a_r10_irq_gate: assert property (@(posedge clk) disable iff (rst)
    !master |=> !irq);

  a_r12_master_stall: assert property (@(posedge clk) disable iff (rst)
    !master |-> !ext_valid);
endmodule

bind pkt_xfer_fifo pxf_checker #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .master(master_q),
  .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_addr(ext_addr),
  .irq(irq), .busy(busy), .done_flg(done_flg), .cnt(cnt), .len(len_q),
  .level(fifo_lvl)
);

// File: tb/tb_pkt_xfer_fifo.sv
`timescale 1ns/1ps
module tb_pkt_xfer_fifo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [6:0]  cpu_addr = '0;
  logic [3:0]  cpu_be = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq, alarm, ext_valid, ext_write;
  logic        ext_ready = 1'b1;
  logic [7:0]  ext_cs;
  logic [31:0] ext_addr, ext_wdata;
  logic [31:0] ext_rdata = '0;

  localparam logic [31:0] RKEY = 32'hA5A50000;

  int checks = 0, fails = 0, cyc = 0;
  logic tog = 1'b0;
  logic [31:0] log_a [0:255];
  logic [31:0] log_d [0:255];
  logic [7:0]  log_cs [0:255];
  logic        log_wr [0:255];
  int log_n = 0;

  pkt_xfer_fifo #(.FIFO_BYTES(64)) dut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq(irq), .alarm(alarm),
    .ext_valid(ext_valid), .ext_ready(ext_ready), .ext_write(ext_write),
    .ext_cs(ext_cs), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata)
  );

  always #2.5 clk = ~clk;

  // External bus model: decides ready, supplies read data, logs every word
  always @(negedge clk) begin
    if (tog) ext_ready = ~ext_ready;
    else     ext_ready = 1'b1;
    ext_rdata = ext_addr ^ RKEY;
    if (ext_valid && ext_ready && log_n < 256) begin
      log_a[log_n]  = ext_addr;
      log_d[log_n]  = ext_write ? ext_wdata : ext_rdata;
      log_cs[log_n] = ext_cs;
      log_wr[log_n] = ext_write;
      log_n = log_n + 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    cpu_addr = a; cpu_re = 1'b1;
    @(negedge clk);
    cpu_re = 1'b0;
    v = cpu_rdata;
  endtask

  task automatic flush_fifo(input logic [31:0] keep);
    wr(7'h0C, keep | 32'h01010000);
    wr(7'h0C, keep);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 alarm", {31'd0, alarm}, 32'd0);
    check("R1 ext_valid", {31'd0, ext_valid}, 32'd0);
    rd(7'h0C, v); check("R1 enable", v, 32'h0);
    rd(7'h14, v); check("R1 status", v, 32'h0);
    rd(7'h44, v); check("R1 fifo status", v, 32'h00010000);
  endtask

  task automatic t_start();
    logic [31:0] v;
    int n0;
    n0 = log_n;
    wr(7'h08, 32'h5A000008);
    wr(7'h0C, 32'h00000301);
    wr(7'h40, 32'h11112222);
    wr(7'h40, 32'h33334444);
    wr(7'h04, 32'h00001000);
    wr(7'h00, 32'h01000008, 4'b0111);   // bit 24 set but lane 3 disabled
    idle(5);
    check("R2 no start without lane 3", log_n - n0, 0);
    wr(7'h00, 32'h01000000, 4'b1000);
    idle(6);
    check("R2 started words", log_n - n0, 2);
    check("R3 first addr", log_a[n0], 32'h00001000);
    check("R3 second addr", log_a[n0+1], 32'h00001004);
    check("R3 order", log_d[n0+1], 32'h33334444);
    check("R13 cs", {24'd0, log_cs[n0]}, 32'h5A);
    check("R13 write dir", {31'd0, log_wr[n0]}, 32'd1);
    rd(7'h14, v); check("R5 complete status", v, 32'h01000008);
    check("R10 done irq", {31'd0, irq}, 32'd1);
    wr(7'h14, 32'h01000000);
    idle(2);
    rd(7'h14, v); check("R8 w1c keeps count", v, 32'h00000008);
    check("R10 irq drops", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    int n0;
    n0 = log_n;
    wr(7'h40, 32'hAAAA0001);
    wr(7'h40, 32'hAAAA0002);
    wr(7'h40, 32'hAAAA0003);
    wr(7'h00, 32'h00000006, 4'b0111);
    wr(7'h00, 32'h01000000, 4'b1000);
    idle(6);
    check("R5 clamp words", log_n - n0, 2);
    rd(7'h14, v); check("R5 clamp count", v, 32'h01000006);
    rd(7'h44, v); check("R5 leftover fill", v, 32'h00000004);
    flush_fifo(32'h00000301);
    rd(7'h44, v); check("R9 flush empties", v, 32'h00010000);
  endtask

  task automatic t_long_write();
    logic [31:0] v;
    int n0, bad;
    n0 = log_n; bad = 0;
    wr(7'h04, 32'h00002000);
    wr(7'h00, 32'h00000100, 4'b0111);
    wr(7'h00, 32'h01000000, 4'b1000);
    for (int k = 0; k < 64; k++) wr(7'h40, 32'hC0DE0000 + k);
    idle(10);
    check("R6 long write words", log_n - n0, 64);
    for (int k = 0; k < 64; k++)
      if (log_a[n0+k] !== 32'h2000 + 4*k || log_d[n0+k] !== 32'hC0DE0000 + k) bad++;
    check("R3 long write order/addr", bad, 0);
    rd(7'h14, v); check("R6 long write done", v, 32'h01000100);
  endtask

  task automatic t_read();
    logic [31:0] v;
    int n0, bad;
    n0 = log_n; bad = 0;
    wr(7'h08, 32'h33010000);
    wr(7'h04, 32'h00003000);
    wr(7'h00, 32'h00000080, 4'b0111);
    tog = 1'b1;
    wr(7'h00, 32'h01000000, 4'b1000);
    idle(40);
    check("R13 inbound dir", {31'd0, log_wr[n0]}, 32'd0);
    check("R13 inbound cs", {24'd0, log_cs[n0]}, 32'h33);
    for (int k = 0; k < 32; k++) begin
      rd(7'h40, v);
      if (v !== ((32'h3000 + 4*k) ^ RKEY)) bad++;
    end
    check("R4 inbound data order", bad, 0);
    tog = 1'b0;
    idle(5);
    rd(7'h14, v); check("R6 inbound done", v, 32'h01000080);
    rd(7'h44, v); check("R4 fifo drained", v, 32'h00010000);
  endtask

  task automatic t_full();
    logic [31:0] v;
    int n0;
    wr(7'h08, 32'h00000008);
    flush_fifo(32'h00000301);
    for (int k = 0; k < 17; k++) wr(7'h40, 32'hF00D0000 + k);
    rd(7'h44, v); check("R7 full fill", v, 32'h00020040);
    n0 = log_n;
    wr(7'h00, 32'h00000040, 4'b0111);
    wr(7'h00, 32'h01000000, 4'b1000);
    idle(20);
    check("R7 words out", log_n - n0, 16);
    check("R7 last kept word", log_d[n0+15], 32'hF00D000F);
    rd(7'h44, v); check("R7 dropped word absent", v, 32'h00010000);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) wr(7'h40, 32'hBEEF0000 + k);
    wr(7'h04, 32'h00004000);
    wr(7'h00, 32'h00000040, 4'b0111);
    wr(7'h00, 32'h01000000, 4'b1000);
    idle(10);
    rd(7'h14, v); check("R5 partial count", v, 32'h00000010);
    wr(7'h0C, 32'h01010301);
    idle(3);
    rd(7'h14, v); check("R9 abort status", v, 32'h10000000);
    check("R10 abort irq", {31'd0, irq}, 32'd1);
    check("R9 halted", {31'd0, ext_valid}, 32'd0);
    wr(7'h0C, 32'h00000301);
    wr(7'h14, 32'h10000000);
    idle(2);
    rd(7'h14, v); check("R8 abort cleared", v, 32'h0);
    check("R10 irq after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_master();
    logic [31:0] v;
    int n0;
    n0 = log_n;
    wr(7'h0C, 32'h00000300);
    wr(7'h40, 32'h12340000);
    wr(7'h40, 32'h12340001);
    wr(7'h00, 32'h00000008, 4'b0111);
    wr(7'h00, 32'h01000000, 4'b1000);
    idle(6);
    check("R12 stalled", log_n - n0, 0);
    rd(7'h14, v); check("R12 busy no count", v, 32'h0);
    wr(7'h0C, 32'h00000001);
    idle(6);
    check("R12 resumed", log_n - n0, 2);
    rd(7'h14, v); check("R12 done", v, 32'h01000008);
    check("R10 masked", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    wr(7'h4C, 32'd20);
    idle(3);
    rd(7'h44, v); check("R11 out empty alarm", v, 32'h00050000);
    for (int k = 0; k < 5; k++) wr(7'h40, k);
    idle(2);
    rd(7'h44, v); check("R11 out at watermark", v, 32'h00000014);
    flush_fifo(32'h00000001);
    wr(7'h08, 32'h00010000);
    wr(7'h4C, 32'd60);
    wr(7'h00, 32'h00000008, 4'b0111);
    wr(7'h00, 32'h01000000, 4'b1000);
    idle(6);
    rd(7'h44, v); check("R11 in alarm", v, 32'h00040008);
    check("R11 alarm pin", {31'd0, alarm}, 32'd1);
    wr(7'h4C, 32'd50);
    idle(3);
    rd(7'h44, v); check("R11 in below", v, 32'h00000008);
    check("R11 alarm pin low", {31'd0, alarm}, 32'd0);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_start();
    t_clamp();
    t_long_write();
    t_read();
    t_full();
    t_abort();
    t_master();
    t_alarm();
    summary();
    $finish;
  end
endmodule